// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Shoot-Through Guard

This block sits between a controller's two switch commands (one for the upper switch, one for the lower switch of a half-bridge) and the drive outputs that feed the gate stages. It removes any overlap between the two commands and, depending on a 2-bit mode input, adds a minimum gap, measured in clock cycles, at every handover between the two sides.

Four behaviours are picked at run time. Guard mode only turns overlap into an equal gap and leaves a positive controller gap untouched. Programmable mode waits at least a programmed number of cycles after one output drops before the other may rise, and keeps the controller's own gap when that is longer. Maximum mode does the same with a fixed longest gap set by a parameter. Bypass mode passes both commands straight through and lets them overlap. Turning off is never delayed: an output drops in the same cycle its command drops.

Each side has a turn-on timer that counts the cycles since the opposite output was last high. An output rises only when its command is high and its timer has reached the effective gap. A turn-on that is still waiting when its command drops is cancelled, and the wait starts again from that point.

Top module: `halfbridge_gap_guard`

## Requirements
- R1: After reset with both commands low, both outputs are low, and a first command then asserts its output in the same cycle, because both timers start out expired.
- R2: With mode_sel = 0 (guard), hs_drv is high exactly when hs_cmd is high and ls_cmd is low, and ls_drv is high exactly when ls_cmd is high and hs_cmd is low, so an overlap of N cycles becomes a gap of N cycles between the outputs.
- R3: With mode_sel = 1 (programmable), an output rises only after the opposite output has been low for at least gap_cycles consecutive cycles; when the controller's gap is longer, the output rises in the cycle its command rises.
- R4: With mode_sel = 2 (maximum), the rule of R3 applies with the gap fixed at the parameter MAX_GAP, whatever gap_cycles holds.
- R5: With mode_sel = 3 (bypass), hs_drv equals hs_cmd and ls_drv equals ls_cmd in every cycle, including cycles where both are high.
- R6: An output is low in every cycle in which its own command is low; turn-off is never delayed.
- R7: If a command drops while its turn-on is still waiting, the wait is cancelled; after the command returns, the output rises no earlier than the effective gap plus one cycle after the cycle in which the command dropped.
- R8: In modes 0, 1 and 2, hs_drv and ls_drv are never high in the same cycle.
- R9: The gap rule is applied the same way to the upper-to-lower and the lower-to-upper handover, giving the same gap in cycles for the same setting.
- R10: If both sides become ready to turn on in the same cycle, neither output asserts until one of the commands drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 guard, 1 programmable, 2 maximum, 3 bypass |
| gap_cycles | input | GW | Programmed gap in clock cycles (used in mode 1) |
| hs_cmd | input | 1 | Upper-switch command from the controller |
| ls_cmd | input | 1 | Lower-switch command from the controller |
| hs_drv | output | 1 | Upper-switch drive output |
| ls_drv | output | 1 | Lower-switch drive output |

## Verification
Directed handovers are run with overlapping commands, with a controller gap shorter than the programmed one and with one longer, so that guard conversion, programmed-gap enforcement and controller-gap pass-through each produce a different measured gap. The same handover is run in both directions to expose any asymmetry, and maximum mode is run with a small gap_cycles value so that an output using the register instead of MAX_GAP is seen. A short command pulse during a pending turn-on separates a timer that restarts from one that keeps counting, and simultaneous command rises exercise the tie rule. Random command runs in every mode are compared cycle by cycle with a reference model, and the overlap rule is checked in every non-bypass cycle.

// File: rtl/gg_pkg.sv
package gg_pkg;

  typedef enum logic [1:0] {
    GG_GUARD = 2'd0,
    GG_PROG  = 2'd1,
    GG_MAX   = 2'd2,
    GG_PASS  = 2'd3
  } gg_mode_e;

  localparam int GG_SIDES = 2;
  localparam int GG_HS    = 0;
  localparam int GG_LS    = 1;

endpackage

// File: rtl/gg_gap_sel.sv
module gg_gap_sel #(
  parameter int GW      = 8,
  parameter int MAX_GAP = 50
) (
  input  logic [1:0]    mode_sel,
  input  logic [GW-1:0] gap_cycles,
  output logic [GW-1:0] gap_eff,
  output logic          pass_thru
);
  import gg_pkg::*;

  localparam logic [GW-1:0] TOP_GAP = GW'(MAX_GAP);

  gg_mode_e mode;

  always_comb begin
    mode = gg_mode_e'(mode_sel);
    pass_thru = 1'b0;
    unique case (mode)
      GG_GUARD: gap_eff = '0;
      GG_PROG:  gap_eff = gap_cycles;
      GG_MAX:   gap_eff = TOP_GAP;
      default: begin
        gap_eff   = '0;
        pass_thru = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/gg_turnon_timer.sv
module gg_turnon_timer #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opp_drv,
  input  logic          own_cmd,
  input  logic          own_drv,
  input  logic [GW-1:0] gap_eff,
  output logic          ready
);

  localparam logic [GW-1:0] CNT_TOP = '1;

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          pend_q, pend_d;
  logic          cancel;

  // next-state
  always_comb begin
    cancel = pend_q & ~own_cmd;
    pend_d = own_cmd & ~own_drv;
    if (opp_drv || cancel) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = (cnt_q != CNT_TOP);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_TOP;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign ready = (cnt_q >= gap_eff);

endmodule

// File: rtl/halfbridge_gap_guard.sv
module halfbridge_gap_guard #(
  parameter int GW      = 8,
  parameter int MAX_GAP = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic [GW-1:0] gap_cycles,
  input  logic          hs_cmd,
  input  logic          ls_cmd,
  output logic          hs_drv,
  output logic          ls_drv
);
  import gg_pkg::*;

  logic [GW-1:0]       gap_eff;
  logic                pass_thru;
  logic [GG_SIDES-1:0] cmd, drv, rdy, elig, arb;

  assign cmd[GG_HS] = hs_cmd;
  assign cmd[GG_LS] = ls_cmd;

  gg_gap_sel #(.GW(GW), .MAX_GAP(MAX_GAP)) u_sel (
    .mode_sel  (mode_sel),
    .gap_cycles(gap_cycles),
    .gap_eff   (gap_eff),
    .pass_thru (pass_thru)
  );

  for (genvar s = 0; s < GG_SIDES; s++) begin : g_side
    gg_turnon_timer #(.GW(GW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .opp_drv(drv[GG_SIDES-1-s]),
      .own_cmd(cmd[s]),
      .own_drv(drv[s]),
      .gap_eff(gap_eff),
      .ready  (rdy[s])
    );
  end

  always_comb begin
    elig = cmd & rdy;
    arb[GG_HS] = elig[GG_HS] & ~elig[GG_LS];
    arb[GG_LS] = elig[GG_LS] & ~elig[GG_HS];
    drv = pass_thru ? cmd : arb;
  end

  assign hs_drv = drv[GG_HS];
  assign ls_drv = drv[GG_LS];

endmodule

// File: rtl/gg_chk.sv
module gg_chk #(
  parameter int GW      = 8,
  parameter int MAX_GAP = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_sel,
  input logic [GW-1:0] gap_cycles,
  input logic          hs_cmd,
  input logic          ls_cmd,
  input logic          hs_drv,
  input logic          ls_drv
);

  localparam logic [GW-1:0] Q_TOP   = '1;
  localparam logic [GW-1:0] TOP_GAP = GW'(MAX_GAP);

  logic [GW-1:0] hs_quiet, ls_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_quiet <= Q_TOP;
      ls_quiet <= Q_TOP;
    end else begin
      if (ls_drv) hs_quiet <= '0;
      else if (hs_quiet != Q_TOP) hs_quiet <= hs_quiet + 1'b1;
      if (hs_drv) ls_quiet <= '0;
      else if (ls_quiet != Q_TOP) ls_quiet <= ls_quiet + 1'b1;
    end
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'd3) |-> !(hs_drv && ls_drv));

  // R5
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd3) |-> (hs_drv == hs_cmd && ls_drv == ls_cmd));

  // R6
  hs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_cmd |-> !hs_drv);

  // R6
  ls_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_cmd |-> !ls_drv);

  // R2
  guard_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0) |-> (hs_drv == (hs_cmd && !ls_cmd) && ls_drv == (ls_cmd && !hs_cmd)));

  // R3
  hs_prog_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd1 && $rose(hs_drv)) |-> (hs_quiet >= gap_cycles));

  // R3
  ls_prog_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd1 && $rose(ls_drv)) |-> (ls_quiet >= gap_cycles));

  // R4
  hs_max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && $rose(hs_drv)) |-> (hs_quiet >= TOP_GAP));

  // R4
  ls_max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && $rose(ls_drv)) |-> (ls_quiet >= TOP_GAP));

endmodule

bind halfbridge_gap_guard gg_chk #(.GW(GW), .MAX_GAP(MAX_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .gap_cycles(gap_cycles),
  .hs_cmd    (hs_cmd),
  .ls_cmd    (ls_cmd),
  .hs_drv    (hs_drv),
  .ls_drv    (ls_drv)
);

// File: tb/sim_halfbridge_gap_guard.sv
`timescale 1ns/1ps
module sim_halfbridge_gap_guard;

  localparam int GW   = 8;
  localparam int MAXG = 50;

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic [GW-1:0] gap_cycles;
  logic          hs_cmd, ls_cmd;
  logic          hs_drv, ls_drv;

  halfbridge_gap_guard #(.GW(GW), .MAX_GAP(MAXG)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .gap_cycles(gap_cycles),
    .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .hs_drv(hs_drv), .ls_drv(ls_drv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state: last cycle each side was blocked
  int t = 0;
  int blk_hs = -100000;
  int blk_ls = -100000;
  bit pend_hs = 0, pend_ls = 0;
  bit prev_h = 0, prev_l = 0;
  int t_hf = 0, t_hr = 0, t_lf = 0, t_lr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, t);
    end
  endtask

  function automatic int eff_gap();
    case (mode_sel)
      2'd0: return 0;
      2'd1: return int'(gap_cycles);
      2'd2: return MAXG;
      default: return 0;
    endcase
  endfunction

  task automatic tick(input logic h, input logic l);
    int  ge;
    bit  rh, rl, a, b, eh, el;
    string req;
    hs_cmd = h;
    ls_cmd = l;
    #1;
    ge = eff_gap();
    rh = (t - blk_hs - 1) >= ge;
    rl = (t - blk_ls - 1) >= ge;
    if (mode_sel == 2'd3) begin
      eh = h; el = l;
    end else begin
      a = h & rh; b = l & rl;
      eh = a & ~b; el = b & ~a;
    end
    case (mode_sel)
      2'd0: req = "R2";
      2'd1: req = "R3";
      2'd2: req = "R4";
      default: req = "R5";
    endcase
    chk(hs_drv == eh, req, "hs_drv", int'(hs_drv), int'(eh));
    chk(ls_drv == el, req, "ls_drv", int'(ls_drv), int'(el));
    if (mode_sel != 2'd3)
      chk(!(hs_drv && ls_drv), "R8", "both high", int'(hs_drv && ls_drv), 0);
    if (!h) chk(!hs_drv, "R6", "hs_drv with hs_cmd low", int'(hs_drv), 0);
    if (!l) chk(!ls_drv, "R6", "ls_drv with ls_cmd low", int'(ls_drv), 0);
    if (el || (pend_hs && !h)) blk_hs = t;
    if (eh || (pend_ls && !l)) blk_ls = t;
    pend_hs = h & ~eh;
    pend_ls = l & ~el;
    if (prev_h && !hs_drv) t_hf = t;
    if (!prev_h && hs_drv) t_hr = t;
    if (prev_l && !ls_drv) t_lf = t;
    if (!prev_l && ls_drv) t_lr = t;
    prev_h = hs_drv;
    prev_l = ls_drv;
    t++;
    @(negedge clk);
  endtask

  task automatic run(input logic h, input logic l, input int n);
    for (int i = 0; i < n; i++) tick(h, l);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    int nhigh;
    logic h, l;
    void'($urandom(32'd1311));
    rst_n = 1'b0;
    mode_sel = 2'd1;
    gap_cycles = GW'(6);
    hs_cmd = 1'b0;
    ls_cmd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and immediate first turn-on
    tick(0, 0);
    chk(!hs_drv && !ls_drv, "R1", "outputs after reset", int'({hs_drv, ls_drv}), 0);
    tick(1, 0);
    chk(hs_drv, "R1", "first hs turn-on immediate", int'(hs_drv), 1);
    run(1, 0, 3);
    // R6: drop in the same cycle
    c = t;
    tick(0, 0);
    chk(t_hf == c, "R6", "hs fall cycle", t_hf, c);
    run(0, 0, 20);

    // R2: guard converts 3-cycle overlap into 3-cycle gap
    mode_sel = 2'd0;
    run(1, 0, 4);
    run(1, 1, 3);
    run(0, 1, 4);
    chk(t_lr - t_hf == 3, "R2", "guard gap from overlap", t_lr - t_hf, 3);
    run(0, 0, 3);
    run(1, 0, 4);
    run(0, 0, 5);
    run(0, 1, 3);
    chk(t_lr - t_hf == 5, "R2", "guard passes controller gap", t_lr - t_hf, 5);
    run(0, 0, 20);

    // R3: programmed gap dominates a short controller gap
    mode_sel = 2'd1;
    gap_cycles = GW'(6);
    run(1, 0, 5);
    run(0, 0, 2);
    run(0, 1, 8);
    chk(t_lr - t_hf == 6, "R3", "programmed gap hs->ls", t_lr - t_hf, 6);
    run(0, 0, 20);
    run(1, 0, 5);
    run(0, 0, 10);
    run(0, 1, 5);
    chk(t_lr - t_hf == 10, "R3", "longer controller gap kept", t_lr - t_hf, 10);

    // R9: opposite direction gives the same gap
    run(0, 0, 1);
    run(1, 0, 8);
    chk(t_hr - t_lf == 6, "R9", "programmed gap ls->hs", t_hr - t_lf, 6);
    run(0, 0, 20);

    // R4: maximum gap ignores a small register value
    mode_sel = 2'd2;
    gap_cycles = GW'(3);
    run(1, 0, 5);
    run(0, 1, 60);
    chk(t_lr - t_hf == MAXG, "R4", "maximum gap", t_lr - t_hf, MAXG);
    run(0, 0, 60);

    // R7: cancelled pending turn-on restarts the wait
    mode_sel = 2'd1;
    gap_cycles = GW'(6);
    run(1, 0, 5);
    run(0, 0, 1);
    run(0, 1, 2);
    c = t;
    run(0, 0, 1);
    run(0, 1, 10);
    chk(t_lr - c == 7, "R7", "turn-on after cancel", t_lr - c, 7);
    run(0, 0, 20);

    // R10: simultaneous readiness blocks both
    gap_cycles = GW'(4);
    nhigh = 0;
    for (int i = 0; i < 5; i++) begin
      tick(1, 1);
      nhigh += int'(hs_drv) + int'(ls_drv);
    end
    chk(nhigh == 0, "R10", "highs during tie", nhigh, 0);
    tick(1, 0);
    chk(hs_drv, "R10", "hs after ls command drops", int'(hs_drv), 1);
    run(0, 0, 20);

    // R5: bypass allows overlap
    mode_sel = 2'd3;
    tick(1, 1);
    chk(hs_drv && ls_drv, "R5", "bypass overlap", int'({hs_drv, ls_drv}), 3);
    run(0, 0, 10);

    // random command runs in every mode
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      gap_cycles = GW'(1 + ($urandom % 12));
      h = 0; l = 0;
      for (int i = 0; i < 600; i++) begin
        if (($urandom % 4) == 0) h = ~h;
        if (($urandom % 4) == 0) l = ~l;
        tick(h, l);
      end
      run(0, 0, 60);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule